// File: doc/BRIEF.md
# Paged Program Counter with Two-Level Return Stack

This block holds the fetch address for a 1K-word program memory and decides, every clock, where the next address comes from. It can stay put, step to the following word, or take a low byte written by the ALU. It can also take a jump or call target from the instruction word, or restore an address saved by an earlier call. The 10-bit address is split into three fields: a high bit (9), a page bit (8) and a low byte (7..0). Each field draws on a different source depending on the operation. The page bit normally comes from a page-select flag held in the status register. On a return, the whole address comes back from the stack.

A two-entry return stack keeps the addresses that calls save. Calls nest two deep. A deeper nesting silently loses the oldest saved address, and a return with nothing saved hands back whatever the stack entry still holds. The instruction decoder drives the command inputs. A return that also loads a constant into the accumulator appears here only as a plain return.

Top module: `paged_pc`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to 000h and clears both stack entries to 000h, so a return issued right after reset lands on 000h.
- R2: With only the advance input active, the address increases by one each cycle and wraps from 3FFh to 000h.
- R3: With no command input active, the address keeps its value.
- R4: A direct write (with no jump, call or return) loads address {0, page, write byte}: bit 9 is cleared, bit 8 takes the page input and bits 7..0 take the ALU byte.
- R5: A jump loads {target bit 9, page, target bits 7..0}; target bit 8 has no effect on the result.
- R6: A call loads {0, page, target bits 7..0} and saves the current address plus one, wrapped to 10 bits, on top of the stack.
- R7: A return loads the top stack entry into the address; the lower entry moves to the top and itself keeps its old value.
- R8: A third call with two addresses already saved discards the oldest one; the two most recent addresses come back in reverse order of saving.
- R9: When several command inputs are active together, return wins over call, call over jump, jump over direct write, and direct write over advance.
- R10: A return with no saved address still loads the current top entry, which after a pop equals the lower entry, with no error indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv | input | 1 | Step to the next sequential address |
| wr_en | input | 1 | Direct write of the low byte from the ALU |
| wr_data | input | 8 | ALU byte for a direct write |
| jmp_en | input | 1 | Jump command |
| call_en | input | 1 | Call command |
| ret_en | input | 1 | Return command (any return variant) |
| tgt | input | 10 | Target field from the instruction word |
| page | input | 1 | Page-select flag from the status register |
| pc | output | 10 | Current fetch address |

## Verification
The bench steps through the whole 1024-word space, so a counter that saturates or fails to wrap at 3FFh shows up at once. It writes every byte under both page values and sweeps every jump target with the page input opposite to target bit 8, which exposes a design that takes bit 8 from the wrong source or keeps bit 9 on a direct write. Nested calls three deep, followed by returns past empty, catch a stack that pushes the wrong return address, drops the newest entry instead of the oldest, or clears an entry on pop. All 32 combinations of the command inputs catch any reordering of the priority chain.

// File: rtl/pc_pkg.sv
package pc_pkg;

    localparam int unsigned PC_W    = 10;
    localparam int unsigned LOW_W   = 8;
    localparam int unsigned STK_D   = 2;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_STEP,
        OP_WRITE,
        OP_JUMP,
        OP_CALL,
        OP_RET
    } pc_op_e;

    typedef struct packed {
        logic adv;
        logic wr;
        logic jmp;
        logic call;
        logic ret;
    } pc_cmd_t;

    // Fixed priority: return, call, jump, write, step.
    function automatic pc_op_e decode_op(pc_cmd_t c);
        if (c.ret)       return OP_RET;
        else if (c.call) return OP_CALL;
        else if (c.jmp)  return OP_JUMP;
        else if (c.wr)   return OP_WRITE;
        else if (c.adv)  return OP_STEP;
        else             return OP_HOLD;
    endfunction

endpackage

// File: rtl/pc_next_sel.sv
module pc_next_sel
    import pc_pkg::*;
#(
    parameter int unsigned AW = PC_W,
    parameter int unsigned LW = LOW_W
) (
    input  pc_op_e           op,
    input  logic [AW-1:0]    cur,
    input  logic [LW-1:0]    wr_byte,
    input  logic [AW-1:0]    tgt,
    input  logic             page,
    input  logic [AW-1:0]    stk_top,
    output logic [AW-1:0]    nxt,
    output logic [AW-1:0]    seq
);
    localparam int unsigned HW = AW - LW - 1;

    logic [HW-1:0] hi_zero;
    assign hi_zero = '0;
    assign seq     = cur + AW'(1);

    always_comb begin
        unique case (op)
            OP_STEP:  nxt = seq;
            OP_WRITE: nxt = {hi_zero, page, wr_byte};
            OP_JUMP:  nxt = {tgt[AW-1:LW+1], page, tgt[LW-1:0]};
            OP_CALL:  nxt = {hi_zero, page, tgt[LW-1:0]};
            OP_RET:   nxt = stk_top;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/pc_ret_stack.sv
module pc_ret_stack #(
    parameter int unsigned W = 10,
    parameter int unsigned D = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_val,
    output logic [W-1:0] top
);
    logic [W-1:0] ent  [D];
    logic [W-1:0] down [D];
    logic [W-1:0] up   [D];

    for (genvar i = 0; i < D; i++) begin : g_lane
        if (i == 0) begin : g_first
            assign down[i] = push_val;
        end else begin : g_rest
            assign down[i] = ent[i-1];
        end
        if (i == D - 1) begin : g_last
            assign up[i] = ent[i];
        end else begin : g_inner
            assign up[i] = ent[i+1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < D; i++) ent[i] <= '0;
        end else if (push) begin
            for (int i = 0; i < D; i++) ent[i] <= down[i];
        end else if (pop) begin
            for (int i = 0; i < D; i++) ent[i] <= up[i];
        end
    end

    assign top = ent[0];
endmodule

// File: rtl/paged_pc.sv
module paged_pc
    import pc_pkg::*;
#(
    parameter int unsigned AW = PC_W,
    parameter int unsigned LW = LOW_W,
    parameter int unsigned SD = STK_D
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_data,
    input  logic          jmp_en,
    input  logic          call_en,
    input  logic          ret_en,
    input  logic [AW-1:0] tgt,
    input  logic          page,
    output logic [AW-1:0] pc
);
    pc_cmd_t       cmd;
    pc_op_e        op;
    logic [AW-1:0] pc_q;
    logic [AW-1:0] pc_d;
    logic [AW-1:0] pc_seq;
    logic [AW-1:0] stk_top;

    assign cmd = '{adv: adv, wr: wr_en, jmp: jmp_en, call: call_en, ret: ret_en};
    assign op  = decode_op(cmd);

    pc_next_sel #(.AW(AW), .LW(LW)) u_sel (
        .op      (op),
        .cur     (pc_q),
        .wr_byte (wr_data),
        .tgt     (tgt),
        .page    (page),
        .stk_top (stk_top),
        .nxt     (pc_d),
        .seq     (pc_seq)
    );

    pc_ret_stack #(.W(AW), .D(SD)) u_stk (
        .clk      (clk),
        .rst      (rst),
        .push     (op == OP_CALL),
        .pop      (op == OP_RET),
        .push_val (pc_seq),
        .top      (stk_top)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_d;
    end

    assign pc = pc_q;
endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
    parameter int unsigned AW = 10,
    parameter int unsigned LW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          adv,
    input logic          wr_en,
    input logic [LW-1:0] wr_data,
    input logic          jmp_en,
    input logic          call_en,
    input logic          ret_en,
    input logic [AW-1:0] tgt,
    input logic          page,
    input logic [AW-1:0] pc
);
    localparam int unsigned HW = AW - LW - 1;
    localparam logic [HW-1:0] HZ = '0;

    logic no_cmd;
    assign no_cmd = !(adv || wr_en || jmp_en || call_en || ret_en);

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (pc == '0));

    assert_step_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (adv && !wr_en && !jmp_en && !call_en && !ret_en)
        |=> (pc == AW'($past(pc) + AW'(1))));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        no_cmd |=> $stable(pc));

    assert_write_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !jmp_en && !call_en && !ret_en)
        |=> (pc == {HZ, $past(page), $past(wr_data)}));

    assert_jump_R5: assert property (@(posedge clk) disable iff (rst)
        (jmp_en && !call_en && !ret_en)
        |=> (pc == {$past(tgt[AW-1:LW+1]), $past(page), $past(tgt[LW-1:0])}));

    assert_call_R6: assert property (@(posedge clk) disable iff (rst)
        (call_en && !ret_en)
        |=> (pc == {HZ, $past(page), $past(tgt[LW-1:0])}));

    assert_call_ret_R7: assert property (@(posedge clk) disable iff (rst)
        (call_en && !ret_en) ##1 (ret_en && !$past(rst))
        |=> (pc == AW'($past(pc, 2) + AW'(1))));
endmodule

bind paged_pc pc_checker #(.AW(AW), .LW(LW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .adv     (adv),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .jmp_en  (jmp_en),
    .call_en (call_en),
    .ret_en  (ret_en),
    .tgt     (tgt),
    .page    (page),
    .pc      (pc)
);

// File: tb/paged_pc_bench.sv
`timescale 1ns/1ps
module paged_pc_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adv = 1'b0, wr_en = 1'b0, jmp_en = 1'b0, call_en = 1'b0, ret_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [9:0] tgt = '0;
    logic       page = 1'b0;
    logic [9:0] pc;

    int n_chk = 0;
    int n_bad = 0;

    logic [9:0] m_pc;
    logic [9:0] m_stk [2];

    always #4 clk = ~clk;

    paged_pc u_paged_pc (
        .clk(clk), .rst(rst), .adv(adv), .wr_en(wr_en), .wr_data(wr_data),
        .jmp_en(jmp_en), .call_en(call_en), .ret_en(ret_en), .tgt(tgt),
        .page(page), .pc(pc)
    );

    task automatic check(input string tag, input logic [9:0] exp);
        n_chk++;
        if (pc !== exp) begin
            n_bad++;
            $display("FAIL %s: pc=%03h expected=%03h", tag, pc, exp);
        end
    endtask

    // Called at a falling edge: drive, update model, wait one cycle, compare.
    task automatic cyc(input logic a, input logic w, input logic [7:0] d,
                       input logic j, input logic c, input logic r,
                       input logic [9:0] t, input logic p, input string tag);
        logic [9:0] nx;
        adv = a; wr_en = w; wr_data = d; jmp_en = j; call_en = c; ret_en = r;
        tgt = t; page = p;
        if (r) begin
            nx = m_stk[0];
            m_stk[0] = m_stk[1];
        end else if (c) begin
            m_stk[1] = m_stk[0];
            m_stk[0] = m_pc + 10'd1;
            nx = {1'b0, p, t[7:0]};
        end else if (j) nx = {t[9], p, t[7:0]};
        else if (w)     nx = {1'b0, p, d};
        else if (a)     nx = m_pc + 10'd1;
        else            nx = m_pc;
        m_pc = nx;
        @(negedge clk);
        check(tag, m_pc);
    endtask

    task automatic go_to(input logic [9:0] a);
        cyc(0, 0, 8'h00, 1, 0, 0, a, a[8], "R5");
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: pc=%03h expected=done", pc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        m_pc = '0;
        m_stk[0] = '0;
        m_stk[1] = '0;
        repeat (3) @(negedge clk);
        check("R1", 10'h000);
        rst = 1'b0;

        // R1: stack cleared by reset
        cyc(0, 0, 8'h00, 0, 0, 1, 10'h000, 0, "R1");
        check("R1", 10'h000);

        // R2: full sweep with wrap
        for (int i = 0; i < 1025; i++) cyc(1, 0, 8'h00, 0, 0, 0, 10'h000, 0, "R2");

        // R3: hold with noise on data inputs
        for (int i = 0; i < 8; i++) cyc(0, 0, 8'(i * 37), 0, 0, 0, 10'(i * 91), i[0], "R3");

        // R4: every byte under both pages
        go_to(10'h3FF);
        for (int p = 0; p < 2; p++)
            for (int d = 0; d < 256; d++)
                cyc(1, 1, 8'(d), 0, 0, 0, 10'h3FF, p[0], "R4");

        // R5: every target, page opposite to target bit 8
        for (int t = 0; t < 1024; t++) begin
            logic [9:0] tv = 10'(t);
            cyc(1, 1, 8'hA5, 1, 0, 0, tv, ~tv[8], "R5");
        end

        // R6/R7/R8/R10: nested calls
        for (int s = 0; s < 64; s++) begin
            logic [9:0] base = 10'(s * 16 + 15);
            go_to(base);
            cyc(0, 0, 8'h00, 0, 1, 0, 10'(s * 3 + 1), s[0], "R6");
            cyc(0, 0, 8'h00, 0, 1, 0, 10'h2FF, ~s[0], "R6");
            if (s[1]) cyc(0, 0, 8'h00, 0, 1, 0, 10'h3FF, 1, "R8");
            cyc(0, 0, 8'h00, 0, 0, 1, 10'h000, 0, "R7");
            cyc(0, 0, 8'h00, 0, 0, 1, 10'h000, 0, s[1] ? "R8" : "R7");
            cyc(0, 0, 8'h00, 0, 0, 1, 10'h000, 0, "R10");
            cyc(0, 0, 8'h00, 0, 0, 1, 10'h000, 0, "R10");
        end

        // R9: all command combinations
        for (int k = 0; k < 32; k++) begin
            go_to(10'h155);
            cyc(0, 0, 8'h00, 0, 1, 0, 10'h0C3, 1, "R6");
            cyc(k[0], k[1], 8'h5A, k[2], k[3], k[4], 10'h2E7, 0, "R9");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule